// File: doc/BRIEF.md
# Three-State Edge-Driven Phase-Frequency Detector

This block compares two digital waveforms, a reference signal and a feedback (comparator) waveform, using only their rising edges. A rising reference edge raises an "up" request and a rising feedback edge raises a "down" request. When both requests would be pending at once, both are cancelled, so at most one is ever active. The result is presented as a single three-level drive command for an external charge pump: source (drive high), sink (drive low) or float (high impedance). The duty factors of the inputs play no part.

Both inputs are asynchronous to the block. Each one passes through a synchronizer and a rising-edge detector that run on a fast sampling clock. All outputs are registered. The analog pump, the loop filter and the oscillator lie outside the block. With the default two synchronizer stages, a rising input level is sampled at the first clock edge and reaches the outputs at the fourth edge.

Top module: `pfd_tristate`

## Requirements
- R1: The levels and high times of both inputs have no effect on the outputs. Only the cycles in which rising edges occur matter, so two waveforms with the same rising-edge times give the same output sequence.
- R2: A rising edge on `sig_in` makes `up` equal to 1. A rising edge on `cmp_in` makes `dn` equal to 1. A request stays set until the opposite edge arrives.
- R3: With equal input frequencies, if `sig_in` leads `cmp_in` by k sample cycles, the drive sources for exactly k cycles per period. If `sig_in` lags by k cycles, the drive sinks for exactly k cycles per period.
- R4: `up` and `dn` are never 1 at the same time. When the opposite edge arrives while one request is pending, or when both edges arrive in the same cycle, both requests are cleared and the output floats.
- R5: When `sig_in` is faster than `cmp_in`, source cycles outnumber sink cycles. When `sig_in` is slower, sink cycles outnumber source cycles.
- R6: With no rising edges on `sig_in`, the drive never sources, and it sinks after each `cmp_in` edge.
- R7: A synchronous active-high `rst` clears any pending request. At the next clock edge it sets `drive_en`, `drive_level`, `up` and `dn` to 0.
- R8: The drive encoding is as follows. `drive_en`=1 with `drive_level`=1 is source (equals `up`). `drive_en`=1 with `drive_level`=0 is sink (equals `dn`). `drive_en`=0 is float, and `drive_level` reads 0 while floating.
- R9: With `SYNC_STAGES`=2, an input level change sampled at clock edge n first appears on the outputs at clock edge n+3. This is the fourth rising edge counted from the one that samples the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Reference signal (asynchronous) |
| cmp_in | input | 1 | Feedback comparator signal (asynchronous) |
| drive_en | output | 1 | 1 = pump driven, 0 = high impedance |
| drive_level | output | 1 | 1 = source, 0 = sink (valid when driven) |
| up | output | 1 | Up request monitor |
| dn | output | 1 | Down request monitor |

## Verification
The hardest case to reach from the ports is two edges landing in the same sampling cycle. In that case the requests must cancel, and the output must not glitch into source or sink. The stimulus creates this case by running two waveforms with equal periods and zero phase offset, so every rising edge coincides. It also creates edges a few cycles apart, so the bench can count exact pulse widths. A second hard case is the duty-factor independence. To cover it, the bench replays the same edge schedule with very different high times and requires identical source counts.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Pending request held by the detector core.
  typedef enum logic [1:0] {
    PFD_IDLE = 2'b00,
    PFD_UP   = 2'b01,
    PFD_DN   = 2'b10
  } pfd_state_e;

  // Number of asynchronous inputs compared by the detector.
  localparam int PFD_NUM_INPUTS = 2;
  localparam int PFD_SIG_IDX    = 0;
  localparam int PFD_CMP_IDX    = 1;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last;

  // Synchronizer chain, one flop per stage.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[STAGES-1];
  end

  // Single-cycle pulse on a synchronized low-to-high transition.
  assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_up,
  input  logic       set_dn,
  output pfd_state_e state
);

  logic       want_up;
  logic       want_dn;
  pfd_state_e state_nxt;

  always_comb begin
    want_up = (state == PFD_UP) | set_up;
    want_dn = (state == PFD_DN) | set_dn;
    // Both requests pending: the shared clear cancels them together.
    unique case ({want_up, want_dn})
      2'b10:   state_nxt = PFD_UP;
      2'b01:   state_nxt = PFD_DN;
      default: state_nxt = PFD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PFD_IDLE;
    else     state <= state_nxt;
  end

endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pfd_state_e state,
  output logic       drive_en,
  output logic       drive_level,
  output logic       up_o,
  output logic       dn_o
);

  logic src;
  logic snk;

  assign src = (state == PFD_UP);
  assign snk = (state == PFD_DN);

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en    <= 1'b0;
      drive_level <= 1'b0;
      up_o        <= 1'b0;
      dn_o        <= 1'b0;
    end else begin
      drive_en    <= src | snk;
      drive_level <= src;
      up_o        <= src;
      dn_o        <= snk;
    end
  end

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  input  logic cmp_in,
  output logic drive_en,
  output logic drive_level,
  output logic up,
  output logic dn
);

  logic [PFD_NUM_INPUTS-1:0] raw_in;
  logic [PFD_NUM_INPUTS-1:0] rise_vec;
  logic                      sig_rise;
  logic                      cmp_rise;
  pfd_state_e                state;

  assign raw_in[PFD_SIG_IDX] = sig_in;
  assign raw_in[PFD_CMP_IDX] = cmp_in;

  for (genvar ch = 0; ch < PFD_NUM_INPUTS; ch++) begin : g_in
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[ch]),
      .rise (rise_vec[ch])
    );
  end

  assign sig_rise = rise_vec[PFD_SIG_IDX];
  assign cmp_rise = rise_vec[PFD_CMP_IDX];

  pfd_core u_core (
    .clk    (clk),
    .rst    (rst),
    .set_up (sig_rise),
    .set_dn (cmp_rise),
    .state  (state)
  );

  pfd_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .drive_en    (drive_en),
    .drive_level (drive_level),
    .up_o        (up),
    .dn_o        (dn)
  );

endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
  input logic clk,
  input logic rst,
  input logic sig_rise,
  input logic cmp_rise,
  input logic drive_en,
  input logic drive_level,
  input logic up,
  input logic dn
);

  AST_NO_BOTH_REQ: assert property (@(posedge clk) disable iff (rst)
    !(up && dn)); // R4

  AST_RESET_FLOAT: assert property (@(posedge clk)
    rst |=> (!drive_en && !drive_level && !up && !dn)); // R7

  AST_SOURCE_IS_UP: assert property (@(posedge clk) disable iff (rst)
    (drive_en && drive_level) |-> up); // R8

  AST_SINK_IS_DN: assert property (@(posedge clk) disable iff (rst)
    (drive_en && !drive_level) |-> dn); // R8

  AST_FLOAT_LEVEL_LOW: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (!drive_level && !up && !dn)); // R8

  AST_UP_FROM_SIG_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> $past(sig_rise, 2)); // R2

  AST_DN_FROM_CMP_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(dn) |-> $past(cmp_rise, 2)); // R2

endmodule

bind pfd_tristate pfd_tristate_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sig_rise    (sig_rise),
  .cmp_rise    (cmp_rise),
  .drive_en    (drive_en),
  .drive_level (drive_level),
  .up          (up),
  .dn          (dn)
);

// File: tb/tb_pfd_tristate.sv
module tb_pfd_tristate;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic cmp_in = 1'b0;
  logic drive_en, drive_level, up, dn;

  pfd_tristate dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .cmp_in(cmp_in),
    .drive_en(drive_en), .drive_level(drive_level), .up(up), .dn(dn)
  );

  always #4 clk = ~clk; // 125 MHz

  typedef struct {
    logic  en;
    logic  lvl;
    logic  u;
    logic  d;
    string req;
  } exp_t;

  exp_t  q[$];
  int    errors = 0;
  int    checks = 0;
  bit    sb_on  = 1'b0;
  bit    done   = 1'b0;
  string cur_req = "R7";
  logic  m_up = 1'b0, m_dn = 1'b0, p_sig = 1'b0, p_cmp = 1'b0;
  int    src_cnt = 0, snk_cnt = 0;
  int    ref_src = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one sample cycle of input and pushes the expected outputs.
  task automatic step(input logic s, input logic c);
    logic rs, rc, nu, nd;
    exp_t e;
    @(negedge clk);
    sig_in = s;
    cmp_in = c;
    rs = s & ~p_sig;
    rc = c & ~p_cmp;
    p_sig = s;
    p_cmp = c;
    nu = m_up | rs;
    nd = m_dn | rc;
    if (nu && nd) begin
      nu = 1'b0;
      nd = 1'b0;
    end
    m_up = nu;
    m_dn = nd;
    e.en = nu | nd; e.lvl = nu; e.u = nu; e.d = nd; e.req = cur_req;
    q.push_back(e);
  endtask

  // Monitor: compares each output cycle with the item pushed four cycles earlier.
  always begin
    @(negedge clk);
    #1;
    if (sb_on && q.size() > 4) begin
      exp_t e;
      e = q.pop_front();
      check({drive_en, drive_level, up, dn} == {e.en, e.lvl, e.u, e.d}, e.req,
            "en/lvl/up/dn", int'({drive_en, drive_level, up, dn}),
            int'({e.en, e.lvl, e.u, e.d}));
      if (drive_en && drive_level)  src_cnt++;
      if (drive_en && !drive_level) snk_cnt++;
    end
  end

  task automatic do_reset();
    sb_on = 1'b0;
    q.delete();
    @(negedge clk);
    rst = 1'b1; sig_in = 1'b0; cmp_in = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check({drive_en, drive_level, up, dn} == 4'b0000, "R7", "reset outputs",
          int'({drive_en, drive_level, up, dn}), 0);
    rst = 1'b0;
    m_up = 1'b0; m_dn = 1'b0; p_sig = 1'b0; p_cmp = 1'b0;
    src_cnt = 0; snk_cnt = 0;
    sb_on = 1'b1;
  endtask

  task automatic drain();
    repeat (5) step(sig_in, cmp_in);
  endtask

  // Periodic waveforms: period, high time and delay of each input.
  task automatic run(input int sp, input int sh, input int so,
                     input int cp, input int ch, input int co, input int n);
    for (int t = 0; t < n; t++) begin
      step(((t - so + sp * 4) % sp) < sh, ((t - co + cp * 4) % cp) < ch);
    end
    drain();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R7: state after power-up reset.
    do_reset();

    // R9 and R2: latency of a single edge, then the opposite edge cancels (R4).
    sb_on = 1'b0;
    @(negedge clk); sig_in = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check(up == 1'b0, "R9", "up before latency", up, 0);
    end
    @(negedge clk); #1;
    check(up && drive_en && drive_level, "R9", "source at 4th edge",
          int'({up, drive_en, drive_level}), 7);
    repeat (3) @(negedge clk);
    #1;
    check(up == 1'b1, "R2", "up held without new edges", up, 1);
    @(negedge clk); cmp_in = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!up && !dn && !drive_en, "R4", "opposite edge clears",
          int'({up, dn, drive_en}), 0);

    // R3: signal leads by 3 cycles.
    do_reset(); cur_req = "R3";
    run(16, 8, 0, 16, 8, 3, 128);
    check(src_cnt == 24, "R3", "lead source cycles", src_cnt, 24);
    check(snk_cnt == 0, "R3", "lead sink cycles", snk_cnt, 0);
    ref_src = src_cnt;

    // R3 and R8: signal lags by 5 cycles.
    do_reset(); cur_req = "R3 R8";
    run(16, 8, 5, 16, 8, 0, 128);
    check(snk_cnt == 40, "R3", "lag sink cycles", snk_cnt, 40);
    check(src_cnt == 0, "R8", "lag source cycles", src_cnt, 0);

    // R4: coincident edges never drive.
    do_reset(); cur_req = "R4";
    run(16, 8, 0, 16, 8, 0, 128);
    check(src_cnt + snk_cnt == 0, "R4", "aligned drive cycles",
          src_cnt + snk_cnt, 0);

    // R1: same edges as the lead case, very different high times.
    do_reset(); cur_req = "R1";
    run(16, 2, 0, 16, 13, 3, 128);
    check(src_cnt == ref_src, "R1", "duty independence", src_cnt, ref_src);

    // R5: faster signal, then slower signal.
    do_reset(); cur_req = "R5";
    run(10, 5, 0, 14, 7, 0, 140);
    check(src_cnt > snk_cnt, "R5", "fast source dominates", src_cnt, snk_cnt);
    do_reset();
    run(14, 7, 0, 10, 5, 0, 140);
    check(snk_cnt > src_cnt, "R5", "slow sink dominates", snk_cnt, src_cnt);

    // R6: no signal activity.
    do_reset(); cur_req = "R6";
    run(12, 0, 0, 12, 6, 0, 120);
    check(src_cnt == 0, "R6", "no source without signal", src_cnt, 0);
    check(snk_cnt > 0, "R6", "sink present", snk_cnt, 1);

    // R7: reset during an active source clears the pending request.
    do_reset();
    sb_on = 1'b0;
    @(negedge clk); sig_in = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check(drive_en == 1'b1, "R7", "source before reset", drive_en, 1);
    @(negedge clk); rst = 1'b1; sig_in = 1'b0;
    @(negedge clk); #1;
    check({drive_en, up, dn} == 3'b000, "R7", "reset mid-source",
          int'({drive_en, up, dn}), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    check({drive_en, up, dn} == 3'b000, "R7", "request stays cleared",
          int'({drive_en, up, dn}), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule